// File: doc/BRIEF.md
# Serial Width-Tracking Constraint Evaluator

This block decides, one operand width at a time, whether a fixed arithmetic constraint holds over three two's-complement operands X, Y and Z that arrive as serial bit streams. The constraint is `Z == X + Y` (modulo the current width), `X > X_MIN`, `Y > Y_MIN` and `Z < Z_MAX`, and it is joined with a Boolean literal. Every bit that arrives widens the operands by one. After each bit, the outputs tell whether the constraint holds when the bits received so far are read as a k-bit signed number. The newest bit is treated as the sign.

The three bounds are parameters. Their bits are produced on the fly from a cycle counter, and bounds shorter than the current width are sign-extended. At small widths a bound may not fit. The block therefore computes KMIN, the largest signed width that any bound needs, and holds back its `bad` output until the stream is at least KMIN bits wide. `sat` reports the raw result without that guard. A new evaluation begins whenever `start` is raised together with the least significant bits.

Top module: `serial_constraint_eval`

## Requirements
- R1: Operands arrive least significant bit first, one bit per clock. `start` high marks bit 0 and restarts the evaluation. `sat` and `bad` are registered and reflect the k bits accepted up to and including the preceding edge. Both are 0 after reset and until the first `start`.
- R2: The sum term holds at width k when the low k bits of Z equal the low k bits of X + Y. The carry into bit 0 is 0, and the carry out of every bit is fed into the next bit.
- R3: The term X > X_MIN is evaluated signed at width k. The newest bit of X is the sign, and the bound is truncated or sign-extended to k bits.
- R4: The term Y > Y_MIN is evaluated in the same way as R3.
- R5: The term Z < Z_MAX is evaluated signed at width k, in the same way as R3.
- R6: `cond_in` is sampled only in the `start` cycle and held for the rest of the stream. Changes to it in later cycles have no effect on `sat` or `bad`.
- R7: KMIN is the smallest k for which every bound fits in k-bit two's complement. `bad` stays 0 while k < KMIN.
- R8: `bad` equals `sat` whenever k >= KMIN.
- R9: `sat` is the AND of the sum term, the three comparison terms and the held literal, evaluated at width k.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Marks the least significant bit and restarts the evaluation |
| x_bit | input | 1 | Serial bit of operand X |
| y_bit | input | 1 | Serial bit of operand Y |
| z_bit | input | 1 | Serial bit of operand Z |
| cond_in | input | 1 | Boolean literal, captured when `start` is high |
| sat | output | 1 | Constraint holds at the current width, without the guard |
| bad | output | 1 | Constraint holds and the width is at least KMIN |

## Verification
The assertions assume that `start` is raised with the least significant bits and that every later cycle carries a valid bit. The mismatch in the sum term is latched only on that basis. The held literal is only meaningful once a first `start` has been seen. The stimulus drives a bit on every clock with no gaps, starts each new stream directly after the last one, and keeps each stream well below the saturation limit of the width counter. A second instance with a wider bound exercises the guard window, including widths at which the truncated bound gives a different answer than the full bound.

// File: rtl/sce_pkg.sv
package sce_pkg;

    // Smallest two's-complement width that can hold value v.
    function automatic int unsigned signed_width(input int v);
        for (int unsigned k = 1; k < 32; k++) begin
            if ((longint'(v) >= -(64'sd1 <<< (k - 1))) &&
                (longint'(v) <  (64'sd1 <<< (k - 1))))
                return k;
        end
        return 32;
    endfunction

    function automatic int unsigned max3(input int unsigned a,
                                         input int unsigned b,
                                         input int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

    // Bit idx of a bound; indices beyond 31 repeat the sign bit.
    function automatic logic bound_bit(input int v, input int unsigned idx);
        logic [31:0] u;
        u = v;
        if (idx > 31)
            return u[31];
        return u[idx[4:0]];
    endfunction

    typedef struct packed {
        logic carry;
        logic eq;
    } add_state_t;

endpackage

// File: rtl/sce_serial_add_eq.sv
module sce_serial_add_eq (
    input  logic clk,
    input  logic rst_n,
    input  logic first,
    input  logic a_bit,
    input  logic b_bit,
    input  logic s_bit,
    output logic match
);
    import sce_pkg::*;

    add_state_t st_d, st_q;
    logic       cin;
    logic       sum_bit;

    always_comb begin
        cin        = first ? 1'b0 : st_q.carry;
        sum_bit    = a_bit ^ b_bit ^ cin;
        st_d.carry = (a_bit & b_bit) | (cin & (a_bit ^ b_bit));
        st_d.eq    = (first ? 1'b1 : st_q.eq) & ~(s_bit ^ sum_bit);
        match      = st_d.eq;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // A mismatch within a stream is never forgotten
    AST_MISMATCH_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (!first && !st_q.eq) |=> !st_q.eq); // R2

    // Generate case with no incoming carry leaves a carry for the next bit
    AST_CARRY_GEN: assert property (@(posedge clk) disable iff (!rst_n)
        (a_bit && b_bit) |=> st_q.carry); // R2

endmodule

// File: rtl/sce_serial_cmp.sv
module sce_serial_cmp #(
    parameter int BOUND   = 0,
    parameter bit OP_LESS = 1'b1   // 1: op < BOUND, 0: op > BOUND
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              first,
    input  int unsigned       idx,
    input  logic              op_bit,
    output logic              holds
);
    import sce_pkg::*;

    logic ult_d, ult_q;
    logic kb, lhs, rhs, prev;

    always_comb begin
        kb    = bound_bit(BOUND, idx);
        lhs   = OP_LESS ? op_bit : kb;
        rhs   = OP_LESS ? kb     : op_bit;
        prev  = first ? 1'b0 : ult_q;
        // unsigned lhs < rhs over all bits so far
        ult_d = (~lhs & rhs) | (~(lhs & ~rhs) & prev);
        // signed: newest bit is the sign
        holds = (lhs & ~rhs) | (~(lhs ^ rhs) & prev);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ult_q <= 1'b0;
        else        ult_q <= ult_d;
    end

endmodule

// File: rtl/sce_width_guard.sv
module sce_width_guard #(
    parameter int unsigned KMIN  = 1,
    parameter int unsigned CNT_W = 6
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    output int unsigned idx,
    output logic        wide_enough
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic [CNT_W-1:0] cur;

    always_comb begin
        cur         = start ? '0 : cnt_q;
        cnt_d       = (cur == CNT_MAX) ? cur : cur + 1'b1;
        idx         = int'(cur);
        wide_enough = (int'(cur) + 1) >= int'(KMIN);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    AST_START_RESTARTS_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (cnt_q == CNT_W'(1))); // R1

endmodule

// File: rtl/serial_constraint_eval.sv
module serial_constraint_eval #(
    parameter int          X_MIN = 0,
    parameter int          Y_MIN = 0,
    parameter int          Z_MAX = 0,
    parameter int unsigned CNT_W = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic x_bit,
    input  logic y_bit,
    input  logic z_bit,
    input  logic cond_in,
    output logic sat,
    output logic bad
);
    import sce_pkg::*;

    localparam int unsigned KMIN = max3(signed_width(X_MIN),
                                        signed_width(Y_MIN),
                                        signed_width(Z_MAX));

    typedef struct packed {
        logic active;
        logic sat;
        logic bad;
    } top_state_t;

    top_state_t  st_d, st_q;
    logic        hold_q;
    logic        hold_now;
    logic        sum_ok, x_ok, y_ok, z_ok;
    logic        wide_enough;
    int unsigned idx;

    sce_width_guard #(.KMIN(KMIN), .CNT_W(CNT_W)) guard_i (
        .clk(clk), .rst_n(rst_n), .start(start),
        .idx(idx), .wide_enough(wide_enough)
    );

    sce_serial_add_eq add_i (
        .clk(clk), .rst_n(rst_n), .first(start),
        .a_bit(x_bit), .b_bit(y_bit), .s_bit(z_bit), .match(sum_ok)
    );

    sce_serial_cmp #(.BOUND(X_MIN), .OP_LESS(1'b0)) cmp_x_i (
        .clk(clk), .rst_n(rst_n), .first(start), .idx(idx),
        .op_bit(x_bit), .holds(x_ok)
    );

    sce_serial_cmp #(.BOUND(Y_MIN), .OP_LESS(1'b0)) cmp_y_i (
        .clk(clk), .rst_n(rst_n), .first(start), .idx(idx),
        .op_bit(y_bit), .holds(y_ok)
    );

    sce_serial_cmp #(.BOUND(Z_MAX), .OP_LESS(1'b1)) cmp_z_i (
        .clk(clk), .rst_n(rst_n), .first(start), .idx(idx),
        .op_bit(z_bit), .holds(z_ok)
    );

    always_comb begin
        hold_now    = start ? cond_in : hold_q;
        st_d.active = st_q.active | start;
        st_d.sat    = st_d.active & sum_ok & x_ok & y_ok & z_ok & hold_now;
        st_d.bad    = st_d.sat & wide_enough;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // Boolean literal: a plain holding register with no reset value
    always_ff @(posedge clk) begin
        hold_q <= hold_now;
    end

    assign sat = st_q.sat;
    assign bad = st_q.bad;

    AST_BAD_NEEDS_SAT: assert property (@(posedge clk) disable iff (!rst_n)
        bad |-> sat); // R8

    AST_GUARD_FIRST_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (start && (KMIN > 1)) |=> !bad); // R7

    AST_LITERAL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.active && !start) |=> $stable(hold_q)); // R6

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.active |-> (!sat && !bad)); // R1

endmodule

// File: tb/serial_constraint_eval_tb.sv
`timescale 1ns/1ps
module serial_constraint_eval_tb_top;

    localparam int GX = 2;   // bound for the guard instance

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0, x_bit = 1'b0, y_bit = 1'b0, z_bit = 1'b0, cond_in = 1'b0;
    logic sat, bad, sat_g, bad_g;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // Reference state
    bit     m_active = 1'b0;
    bit     m_hold   = 1'b0;
    longint m_x = 0, m_y = 0, m_z = 0;
    int     m_k = 0;

    always #2.5 clk = ~clk;

    serial_constraint_eval dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .x_bit(x_bit), .y_bit(y_bit),
        .z_bit(z_bit), .cond_in(cond_in), .sat(sat), .bad(bad)
    );

    serial_constraint_eval #(.X_MIN(GX)) dut_g_i (
        .clk(clk), .rst_n(rst_n), .start(start), .x_bit(x_bit), .y_bit(y_bit),
        .z_bit(z_bit), .cond_in(cond_in), .sat(sat_g), .bad(bad_g)
    );

    function automatic longint sext(longint v, int k);
        longint m;
        m = (64'sd1 <<< k) - 1;
        v = v & m;
        if (v[k-1]) v = v - (64'sd1 <<< k);
        return v;
    endfunction

    function automatic int min_width(int a, int b, int c);
        int w = 1;
        for (int k = 1; k < 33; k++) begin
            longint lo = -(64'sd1 <<< (k - 1));
            longint hi = (64'sd1 <<< (k - 1));
            if (a >= lo && a < hi && b >= lo && b < hi && c >= lo && c < hi) begin
                w = k;
                break;
            end
        end
        return w;
    endfunction

    function automatic bit exp_sat(int xmin, int ymin, int zmax);
        longint sx, sy, sz, ms;
        if (!m_active || m_k == 0) return 1'b0;
        ms = (64'sd1 <<< m_k) - 1;
        sx = sext(m_x, m_k);
        sy = sext(m_y, m_k);
        sz = sext(m_z, m_k);
        return (((m_x + m_y) & ms) == (m_z & ms)) &&
               (sx > sext(longint'(xmin), m_k)) &&
               (sy > sext(longint'(ymin), m_k)) &&
               (sz < sext(longint'(zmax), m_k)) && m_hold;
    endfunction

    task automatic check(bit act, bit exp, string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0b expected %0b (width %0d)", what, act, exp, m_k);
        end
    endtask

    task automatic compare_all(string tag);
        bit es, esg;
        es  = exp_sat(0, 0, 0);
        esg = exp_sat(GX, 0, 0);
        check(sat, es, {tag, " sat R9"});
        check(bad, es && (m_k >= min_width(0, 0, 0)), {tag, " bad R8"});
        check(sat_g, esg, {tag, " guard-instance sat R9"});
        check(bad_g, esg && (m_k >= min_width(GX, 0, 0)), {tag, " guard-instance bad R7"});
    endtask

    // Streams n bits LSB first; cond_in is inverted after the start cycle (R6)
    task automatic stream(longint xv, longint yv, longint zv, int n, bit c, string tag);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            start   = (i == 0);
            x_bit   = xv[i];
            y_bit   = yv[i];
            z_bit   = zv[i];
            cond_in = (i == 0) ? c : ~c;
            if (i == 0) begin
                m_active = 1'b1; m_hold = c; m_x = 0; m_y = 0; m_z = 0; m_k = 0;
            end
            m_x = m_x | (longint'(xv[i]) <<< i);
            m_y = m_y | (longint'(yv[i]) <<< i);
            m_z = m_z | (longint'(zv[i]) <<< i);
            m_k = m_k + 1;
            @(posedge clk);
            #1;
            compare_all(tag);
        end
    endtask

    initial begin
        fork
            begin
                repeat (4) @(posedge clk);
                #1;
                check(sat, 1'b0, "R1 reset sat");
                check(bad, 1'b0, "R1 reset bad");
                rst_n = 1'b1;
                repeat (3) @(posedge clk);
                #1;
                check(sat, 1'b0, "R1 idle before first start");
                check(bad_g, 1'b0, "R1 idle before first start guard");

                // Width-2 satisfying assignment: bad rises on the second bit
                stream(1, 1, 2, 2, 1'b1, "R2 width2");
                check(bad, 1'b1, "R2 width2 final bad");
                check(bad_g, 1'b0, "R7 truncated bound masked at width 2");
                // Width-4 satisfying assignment
                stream(7, 7, 14, 4, 1'b1, "R3 width4");
                check(bad, 1'b1, "R3 width4 final bad");
                // Long carry chain
                stream(2047, 1, 2048, 12, 1'b1, "R2 carry chain");
                check(bad, 1'b1, "R2 carry chain final bad");
                // Violations
                stream(1, 1, 3, 4, 1'b1, "R2 sum mismatch");
                check(sat, 1'b0, "R2 sum mismatch final");
                stream(0, 9, 9, 5, 1'b1, "R3 x not positive");
                stream(9, 0, 9, 5, 1'b1, "R4 y not positive");
                stream(1, 1, 2, 4, 1'b1, "R5 z not negative");
                check(sat, 1'b0, "R5 z positive final");
                stream(7, 7, 14, 4, 1'b0, "R6 literal false");
                check(sat, 1'b0, "R6 literal false final");
                // Guard instance: x > 2 needs three bits
                stream(3, 5, 8, 4, 1'b1, "R7 guard");
                check(bad_g, 1'b1, "R7 guard final bad");
                stream(5, 6, 11, 6, 1'b1, "R9 mixed");
                done = 1'b1;
            end
            begin
                repeat (20000) @(posedge clk);
                if (!done) begin
                    checks++;
                    fails++;
                    $display("FAIL watchdog: actual hung expected done");
                end
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule